// File: doc/BRIEF.md
# Write Protection Register Controller

This block sits beside the serial bus engine of a small byte-addressed nonvolatile store and owns the write-protect state. Three sources can protect the array. The hardware protect pin blocks writes to every address while it is high. A soft lock blocks writes to the lower half of the array and can be removed again. A permanent lock also blocks writes to the lower half, and nothing except a full reset of the state can remove it.

The bus engine gives the block the decoded fields of the current transfer: the 4-bit device type, the 3-bit select field, the read flag, the word address, and a flag showing a high voltage on the first address strap. From these the block returns, without delay, an acknowledge decision for the command byte, the word-address byte and the data byte. It also returns a write permit for the presented word address. When the data byte of an accepted protect command is taken, the bus engine pulses a commit strobe. The write timer later pulses a completion strobe, and only then does the protect state change. A host can therefore probe the protect state by sending a command and watching which bytes are acknowledged.

Top module: `wprot_ctrl`

## Requirements
- R1: A protect command has device type 4'b0110, `hv_a0` high and `cmd_rd` low. Select 3'b001 is soft-set, 3'b011 is soft-clear and 3'b000 is permanent-set. Any other select value, or `hv_a0` low, gives a command that is not acknowledged. Device type 4'b1010 with `cmd_sel` equal to `strap_sel` is a memory command. Every other device type is never acknowledged.
- R2: With `wp_pin` low, `wr_permit` is high for word addresses 8'h80 to 8'hFF whatever the soft and permanent state. For addresses 8'h00 to 8'h7F, `wr_permit` is low while either the soft or the permanent lock is set.
- R3: With `wp_pin` high, `wr_permit` and `ack_data` are low for every command and address. `ack_cmd` and `ack_word` are unchanged by the pin.
- R4: A memory write acknowledges the command byte and the word byte, and acknowledges the data byte exactly when `wr_permit` is high. A memory read acknowledges only the command byte.
- R5: Without the permanent lock, a protect command acknowledges its command byte, except soft-set while the soft lock is already on. An acknowledged protect write also acknowledges its word byte, and acknowledges its data byte when `wp_pin` is low. With `cmd_rd` high, a protect-type access answers on the command byte by the same rule and acknowledges nothing further.
- R6: Once the permanent lock is set, no protect command of any kind acknowledges any byte.
- R7: The protect state changes only at a clock edge where `cycle_done` is high. The change applies the command captured at an earlier `byte_commit` that saw an acknowledged protect data byte: soft-set turns the soft lock on, soft-clear turns it off, and permanent-set turns the permanent lock on.
- R8: Soft-clear has no effect on the permanent lock, and the permanent lock never falls while `rst_n` is high.
- R9: If `wp_pin` is high at any clock edge between the commit and the completion strobe, the captured command is dropped and the completion leaves the state unchanged.
- R10: After reset both locks are off, so every address is writable with `wp_pin` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the protect state |
| wp_pin | input | 1 | Hardware protect level; high blocks all writes |
| hv_a0 | input | 1 | High-voltage indication on the first address strap |
| strap_sel | input | 3 | Device select straps of this device |
| cmd_type | input | 4 | Device type field of the received command byte |
| cmd_sel | input | 3 | Select field of the received command byte |
| cmd_rd | input | 1 | Read flag of the received command byte |
| word_addr | input | 8 | Word address of the write in progress |
| byte_commit | input | 1 | Pulse: the bus engine has taken the data byte |
| cycle_done | input | 1 | Pulse: the write timer has finished the protect update |
| ack_cmd | output | 1 | Acknowledge the command byte |
| ack_word | output | 1 | Acknowledge the word-address byte |
| ack_data | output | 1 | Acknowledge the data byte (and start a write cycle) |
| wr_permit | output | 1 | The presented word address may be written |

## Verification
The four decisions are combinational. Each one is due in the same cycle that the command fields, the word address and the pin settle. The bench changes these inputs on a falling edge and samples 1 ns later, well before the next rising edge. A protect-state change needs two strobes. The commit is registered at one rising edge, and the completion applies it at a later rising edge. The bench therefore raises and lowers each strobe on successive falling edges and probes the new state only after the completion edge has passed. It also probes once before that edge, to show that a captured but incomplete command has not yet taken effect.

// File: rtl/wprot_ctrl.sv
module wprot_ctrl #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_pin,
  input  logic              hv_a0,
  input  logic [2:0]        strap_sel,
  input  logic [3:0]        cmd_type,
  input  logic [2:0]        cmd_sel,
  input  logic              cmd_rd,
  input  logic [ADDR_W-1:0] word_addr,
  input  logic              byte_commit,
  input  logic              cycle_done,
  output logic              ack_cmd,
  output logic              ack_word,
  output logic              ack_data,
  output logic              wr_permit
);
  localparam logic [3:0] TYPE_MEM  = 4'b1010;
  localparam logic [3:0] TYPE_PROT = 4'b0110;
  localparam logic [2:0] SEL_SET   = 3'b001;
  localparam logic [2:0] SEL_CLR   = 3'b011;
  localparam logic [2:0] SEL_PERM  = 3'b000;

  typedef enum logic [1:0] {P_NONE, P_SET, P_CLR, P_PERM} pend_e;

  logic  soft_q, perm_q;
  pend_e pend_q;

  logic is_mem, is_prot, op_set, op_clr, op_perm, prot_ok, lower_half;

  assign is_mem  = (cmd_type == TYPE_MEM) && (cmd_sel == strap_sel);
  assign op_set  = cmd_sel == SEL_SET;
  assign op_clr  = cmd_sel == SEL_CLR;
  assign op_perm = cmd_sel == SEL_PERM;
  assign is_prot = (cmd_type == TYPE_PROT) && hv_a0 && (op_set || op_clr || op_perm);
  assign prot_ok = is_prot && !perm_q && !(op_set && soft_q);

  assign lower_half = !word_addr[ADDR_W-1];
  assign wr_permit  = !wp_pin && !(lower_half && (soft_q || perm_q));

  assign ack_cmd  = is_mem || prot_ok;
  assign ack_word = !cmd_rd && ack_cmd;
  assign ack_data = !cmd_rd && (is_mem ? wr_permit : (prot_ok && !wp_pin));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= P_NONE;
    end else if (wp_pin || cycle_done) begin
      pend_q <= P_NONE;
    end else if (byte_commit && !cmd_rd && prot_ok) begin
      pend_q <= op_set ? P_SET : (op_clr ? P_CLR : P_PERM);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      soft_q <= 1'b0;
      perm_q <= 1'b0;
    end else if (cycle_done && !wp_pin) begin
      case (pend_q)
        P_SET:   soft_q <= 1'b1;
        P_CLR:   soft_q <= 1'b0;
        P_PERM:  perm_q <= 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/wprot_ctrl_chk.sv
module wprot_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wp_pin,
  input logic [7:0] word_addr,
  input logic [3:0] cmd_type,
  input logic       cycle_done,
  input logic       ack_cmd,
  input logic       ack_data,
  input logic       wr_permit,
  input logic       soft_q,
  input logic       perm_q
);
  a_r2_upper_open: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_pin && word_addr[7]) |-> wr_permit);

  a_r2_lower_locked: assert property (@(posedge clk) disable iff (!rst_n)
    ((soft_q || perm_q) && !word_addr[7]) |-> !wr_permit);

  a_r3_pin_locks: assert property (@(posedge clk) disable iff (!rst_n)
    wp_pin |-> (!wr_permit && !ack_data));

  a_r6_perm_mute: assert property (@(posedge clk) disable iff (!rst_n)
    (perm_q && cmd_type == 4'b0110) |-> !ack_cmd);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cycle_done |=> ($stable(soft_q) && $stable(perm_q)));

  a_r8_perm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    perm_q |=> perm_q);
endmodule

bind wprot_ctrl wprot_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wp_pin(wp_pin), .word_addr(word_addr),
  .cmd_type(cmd_type), .cycle_done(cycle_done), .ack_cmd(ack_cmd),
  .ack_data(ack_data), .wr_permit(wr_permit), .soft_q(soft_q), .perm_q(perm_q)
);

// File: tb/wprot_ctrl_tb_top.sv
module wprot_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wp_pin = 1'b0, hv_a0 = 1'b0, cmd_rd = 1'b0;
  logic byte_commit = 1'b0, cycle_done = 1'b0;
  logic [2:0] strap_sel = 3'b101, cmd_sel = 3'b000;
  logic [3:0] cmd_type = 4'b0000;
  logic [7:0] word_addr = 8'h00;
  logic ack_cmd, ack_word, ack_data, wr_permit;

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;
  bit soft_m = 1'b0, perm_m = 1'b0;

  always #2 clk = ~clk;

  wprot_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wp_pin(wp_pin), .hv_a0(hv_a0), .strap_sel(strap_sel),
    .cmd_type(cmd_type), .cmd_sel(cmd_sel), .cmd_rd(cmd_rd), .word_addr(word_addr),
    .byte_commit(byte_commit), .cycle_done(cycle_done), .ack_cmd(ack_cmd),
    .ack_word(ack_word), .ack_data(ack_data), .wr_permit(wr_permit)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b (type %h sel %0d hv %b rd %b wp %b addr %h)",
               tag, what, act, exp, cmd_type, cmd_sel, hv_a0, cmd_rd, wp_pin, word_addr);
    end
  endtask

  task automatic sweep();
    logic [3:0] types [3];
    logic [7:0] addrs [4];
    types[0] = 4'b1010; types[1] = 4'b0110; types[2] = 4'b0011;
    addrs[0] = 8'h00; addrs[1] = 8'h7F; addrs[2] = 8'h80; addrs[3] = 8'hFF;
    for (int ti = 0; ti < 3; ti++)
      for (int s = 0; s < 8; s++)
        for (int h = 0; h < 2; h++)
          for (int r = 0; r < 2; r++)
            for (int w = 0; w < 2; w++)
              for (int ai = 0; ai < 4; ai++) begin
                bit lower, permit, mem, prot, ok, ec, ew, ed;
                string tg;
                @(negedge clk);
                cmd_type = types[ti]; cmd_sel = 3'(s); hv_a0 = h[0];
                cmd_rd = r[0]; wp_pin = w[0]; word_addr = addrs[ai];
                #1;
                lower  = (addrs[ai] < 8'h80);
                permit = (w == 0) && !(lower && (soft_m || perm_m));
                mem    = (ti == 0) && (3'(s) == strap_sel);
                prot   = (ti == 1) && (h == 1) && (s == 1 || s == 3 || s == 0);
                ok     = prot && !perm_m && !(s == 1 && soft_m);
                ec     = mem || ok;
                ew     = (r == 0) && ec;
                ed     = (r == 0) && (mem ? permit : (ok && w == 0));
                tg = (w == 1) ? "R3" : (lower ? "R2" : "R2");
                chk(tg, "wr_permit", wr_permit, permit);
                if (mem) tg = "R4";
                else if (prot && perm_m) tg = "R6";
                else if (prot) tg = "R5";
                else tg = "R1";
                chk(tg, "ack_cmd", ack_cmd, ec);
                chk(tg, "ack_word", ack_word, ew);
                chk((w == 1) ? "R3" : tg, "ack_data", ack_data, ed);
              end
    @(negedge clk);
    wp_pin = 1'b0; cmd_rd = 1'b0;
  endtask

  task automatic present(input logic [2:0] sel);
    @(negedge clk);
    cmd_type = 4'b0110; cmd_sel = sel; hv_a0 = 1'b1; cmd_rd = 1'b0; wp_pin = 1'b0;
  endtask

  task automatic commit();
    @(negedge clk); byte_commit = 1'b1;
    @(negedge clk); byte_commit = 1'b0;
  endtask

  task automatic done();
    @(negedge clk); cycle_done = 1'b1;
    @(negedge clk); cycle_done = 1'b0;
  endtask

  task automatic probe_soft(input string tag, input bit exp_soft);
    @(negedge clk);
    cmd_type = 4'b1010; cmd_sel = strap_sel; hv_a0 = 1'b0; cmd_rd = 1'b0;
    wp_pin = 1'b0; word_addr = 8'h10;
    #1;
    chk(tag, "wr_permit lower", wr_permit, !(exp_soft || perm_m));
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    probe_soft("R10", 1'b0);
    sweep();

    // R7: soft-set applied only after completion
    present(3'b001); #1;
    chk("R5", "ack_data set", ack_data, 1'b1);
    commit();
    repeat (3) @(negedge clk);
    probe_soft("R7", 1'b0);
    done();
    soft_m = 1'b1;
    probe_soft("R7", 1'b1);
    sweep();

    // R5: soft-set refused while soft lock on
    present(3'b001); #1;
    chk("R5", "ack_cmd set while soft", ack_cmd, 1'b0);

    // R7: soft-clear
    present(3'b011); commit(); done();
    soft_m = 1'b0;
    probe_soft("R7", 1'b0);
    sweep();

    // R9: pin rises while pending
    present(3'b001); commit();
    @(negedge clk); wp_pin = 1'b1;
    @(negedge clk); wp_pin = 1'b0;
    done();
    probe_soft("R9", 1'b0);

    // R7, R8: soft on, then permanent, then clear attempt
    present(3'b001); commit(); done();
    soft_m = 1'b1;
    present(3'b000); commit(); done();
    perm_m = 1'b1;
    present(3'b011); #1;
    chk("R8", "ack_cmd clear under perm", ack_cmd, 1'b0);
    commit(); done();
    probe_soft("R8", 1'b1);
    sweep();

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule